// File: doc/BRIEF.md
# Four-Lane RAW10 Packet Depacketizer

The block takes four byte-wide lanes from a camera serial link after deserialisation. Each lane marks its first byte of a burst with a start pulse. The block lines the four lanes up and rebuilds the packet byte stream, taking lane 0 first and lane 3 last. It decodes the four-byte header and turns 10-bit raw payloads into pixel words. The number of pixels per word is a build parameter. All packet types other than raw 10-bit lines are consumed without producing pixels; a frame-start packet only arms a marker for the next line.

The byte clock may stop between bursts, so nothing in the block counts clock edges as a measure of time. Each 4-pixel group is stored in a small FIFO. A serialiser slices each group into one, two or four output words. Line blanking lets the FIFO drain, because with narrow output words a line produces pixels faster than they can leave.

Top module: `raw10_depacketizer`

## Requirements
- R1: During and after reset, `pix_vld`, `pix_sof`, `pix_sol` and `align_err` are low until a packet is received.
- R2: The lane start pulses may be spread over two consecutive cycles. A lane that pulses in the first cycle is delayed by one cycle, so all four lanes line up. Stream byte 4k+i is then lane i's k-th aligned byte, for every mix of early and late lanes.
- R3: The first aligned word is the header. Lane 0 carries the identifier byte, which is compared whole. Lane 1 carries the low byte of the 16-bit payload count and lane 2 the high byte. The lane 3 check byte is ignored.
- R4: Identifier 0x2B with a nonzero count is a raw 10-bit line. Each 5 payload bytes yield pixels 0 to 3. Pixel k is {byte k, byte 4 bits [2k+1:2k]}.
- R5: Pixels leave in stream order, PPW per word, with one word per cycle while any are buffered. When PPW is 2 or 4, the pixels at even positions in the word take the low half of `pix_data`, lowest first, and the odd ones take the high half. With PPW=2, bits [9:0] hold the even pixel and bits [19:10] the odd pixel.
- R6: `pix_sol` is high on the first word of every raw 10-bit line and on no other word.
- R7: A packet with identifier 0x00 arms a frame marker. `pix_sof` is then high together with `pix_sol` on the first word of the next raw 10-bit line, and only there.
- R8: Every other identifier (for example 0x01, 0x02 or 0x2A) gives no output word, whether the packet is short or long.
- R9: If any lane gives no start pulse by the cycle after the first one, `align_err` pulses for one cycle and the packet gives no output word and arms no marker.
- R10: Bytes after the payload count (checksum, padding) never reach the output. A count that is not a multiple of 4 ends the packet correctly.
- R11: No pixel word is lost or duplicated, provided a line holds at most FIFO_DEPTH groups and the line gap drains the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock (may pause) |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_byte | input | 32 | Lane i byte on bits [8i+7:8i] |
| lane_sot | input | 4 | Per-lane start pulse on its first byte |
| pix_vld | output | 1 | Pixel word valid |
| pix_data | output | PPW*10 | Pixel word, even pixels low, odd pixels high |
| pix_sof | output | 1 | First word of the first line of a frame |
| pix_sol | output | 1 | First word of a line |
| align_err | output | 1 | One-cycle pulse on lane skew failure |

## Verification
A wrong early-lane mask or a bad header decode makes the whole line come out in the wrong byte order or with the wrong length. Either shows up on the first pixel word, one group later than the header. A slip in the gather buffer's byte count corrupts the low two bits of pixels, or shifts every pixel after the first group of the line. It is seen within two words. A FIFO pointer fault or a stale marker shows as a missing, repeated or mislabelled word, or as leftover words. The per-line drain check catches these before the next packet starts.

// File: rtl/raw10_depacketizer.sv
module raw10_depacketizer #(
  parameter int PPW        = 2,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lane_byte,
  input  logic [3:0]        lane_sot,
  output logic              pix_vld,
  output logic [PPW*10-1:0] pix_data,
  output logic              pix_sof,
  output logic              pix_sol,
  output logic              align_err
);
  localparam int PW   = 10;
  localparam int NSUB = 4 / PPW;
  localparam int AW   = $clog2(FIFO_DEPTH);
  localparam int HALF = (PPW > 1) ? PPW / 2 : 1;
  localparam logic [7:0] ID_FRAME = 8'h00;
  localparam logic [7:0] ID_RAW10 = 8'h2B;

  typedef enum logic [1:0] {S_IDLE, S_SKEW, S_PAY} st_t;
  st_t st;

  logic [31:0] dly, aw, inm;
  logic [3:0]  early;
  logic [15:0] rem;
  logic [63:0] gbuf;
  logic [3:0]  gcnt;
  logic        sof_pend, first_grp;

  always_comb
    for (int i = 0; i < 4; i++)
      aw[8*i +: 8] = early[i] ? dly[8*i +: 8] : lane_byte[8*i +: 8];

  wire        hdr_ok = (early | lane_sot) == 4'hF;
  wire [2:0]  nin    = (rem >= 16'd4) ? 3'd4 : rem[2:0];

  always_comb
    for (int i = 0; i < 4; i++)
      inm[8*i +: 8] = (3'(i) < nin) ? aw[8*i +: 8] : 8'h00;

  wire [63:0] merged = gbuf | ({32'h0, inm} << {gcnt, 3'b000});
  wire [3:0]  tot    = gcnt + {1'b0, nin};
  wire        grp    = (st == S_PAY) && (tot >= 4'd5);

  logic [3:0][PW-1:0] gpix;
  always_comb
    for (int k = 0; k < 4; k++)
      gpix[k] = {merged[8*k +: 8], merged[32 + 2*k +: 2]};

  logic [41:0]   mem [FIFO_DEPTH];
  logic [41:0]   cur;
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fcnt;
  logic          busy;
  logic [1:0]    sub;

  wire full = fcnt == (AW+1)'(FIFO_DEPTH);
  wire push = grp && !full;
  wire last = sub == 2'(NSUB - 1);
  wire pop  = (fcnt != '0) && (!busy || last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; dly <= '0; early <= '0; rem <= '0;
      gbuf <= '0; gcnt <= '0; sof_pend <= 1'b0; first_grp <= 1'b0;
      align_err <= 1'b0;
    end else begin
      dly       <= lane_byte;
      align_err <= 1'b0;
      case (st)
        S_IDLE: if (|lane_sot) begin
          early <= lane_sot;
          st    <= S_SKEW;
        end
        S_SKEW: begin
          st <= S_IDLE;
          gbuf <= '0; gcnt <= '0; first_grp <= 1'b1;
          if (!hdr_ok) align_err <= 1'b1;
          else if (aw[7:0] == ID_FRAME) sof_pend <= 1'b1;
          else if (aw[7:0] == ID_RAW10 && aw[23:8] != 16'h0) begin
            rem <= aw[23:8];
            st  <= S_PAY;
          end
        end
        S_PAY: begin
          rem <= rem - 16'(nin);
          if (rem <= 16'd4) st <= S_IDLE;
          if (grp) begin
            gbuf <= merged >> 40;
            gcnt <= tot - 4'd5;
          end else begin
            gbuf <= merged;
            gcnt <= tot;
          end
          if (push) begin
            first_grp <= 1'b0;
            if (first_grp) sof_pend <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {first_grp & sof_pend, first_grp, gpix};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0; cur <= '0; busy <= 1'b0; sub <= '0;
    end else begin
      if (push) wp <= (wp == AW'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) begin
        cur  <= mem[rp];
        rp   <= (rp == AW'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
        sub  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      sub  <= sub + 1'b1;
      end
      fcnt <= fcnt + (AW+1)'(push) - (AW+1)'(pop);
    end

  logic [3:0][PW-1:0] cpix;
  assign cpix    = cur[39:0];
  assign pix_vld = busy;
  assign pix_sol = busy && (sub == 2'd0) && cur[40];
  assign pix_sof = busy && (sub == 2'd0) && cur[41];

  for (genvar j = 0; j < PPW; j++) begin : g_slot
    localparam int SLOT = (PPW == 1) ? 0 : (j % 2) * HALF + j / 2;
    wire [1:0] idx = 2'(int'(sub) * PPW + j);
    assign pix_data[PW*SLOT +: PW] = cpix[idx];
  end
endmodule

// File: rtl/raw10_depacketizer_chk.sv
module raw10_depacketizer_chk #(
  parameter int FIFO_DEPTH = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [3:0]                    lane_sot,
  input logic                          pix_vld,
  input logic                          pix_sof,
  input logic                          pix_sol,
  input logic                          align_err,
  input logic                          grp,
  input logic [$clog2(FIFO_DEPTH):0]   fcnt
);
  localparam int AW = $clog2(FIFO_DEPTH);

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> !align_err);

  p_err_after_sot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> $past(lane_sot, 2) != 4'h0);

  p_sof_with_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> pix_sol);

  p_sol_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |-> pix_vld);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == (AW+1)'(FIFO_DEPTH)) |-> !grp);

  p_fill_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= (AW+1)'(FIFO_DEPTH));
endmodule

bind raw10_depacketizer raw10_depacketizer_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .lane_sot(lane_sot), .pix_vld(pix_vld),
  .pix_sof(pix_sof), .pix_sol(pix_sol), .align_err(align_err),
  .grp(grp), .fcnt(fcnt)
);

// File: tb/tb_raw10_depacketizer.sv
module tb_raw10_depacketizer;
  localparam int CLK_PERIOD = 10;
  localparam int PPW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lane_byte = '0;
  logic [3:0]  lane_sot = '0;
  logic        pix_vld, pix_sof, pix_sol, align_err;
  logic [19:0] pix_data;

  raw10_depacketizer #(.PPW(PPW), .FIFO_DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .lane_byte(lane_byte), .lane_sot(lane_sot),
    .pix_vld(pix_vld), .pix_data(pix_data), .pix_sof(pix_sof),
    .pix_sol(pix_sol), .align_err(align_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, got_err = 0, exp_err = 0;
  bit m_sof = 0, done = 0;
  logic [21:0] expq [$];

  always @(negedge clk) if (rst_n && !done) begin
    if (align_err) got_err++;
    if (pix_vld) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R8/R10/R11 unexpected word: got %h expected none", pix_data);
      end else begin
        logic [21:0] e;
        e = expq.pop_front();
        if (pix_data !== e[19:0]) begin
          fails++;
          $display("FAIL R2/R3/R4/R5 pixel word: got %h expected %h", pix_data, e[19:0]);
        end
        checks++;
        if (pix_sol !== e[20]) begin
          fails++;
          $display("FAIL R6 line marker: got %b expected %b", pix_sol, e[20]);
        end
        checks++;
        if (pix_sof !== e[21]) begin
          fails++;
          $display("FAIL R7 frame marker: got %b expected %b", pix_sof, e[21]);
        end
      end
    end
  end

  task automatic send(input logic [7:0] di, input int wc, input bit is_long,
                      input logic [3:0] late, input logic [3:0] miss);
    logic [7:0] bs [$];
    logic [7:0] pl [$];
    int nwords;
    bs.push_back(di);
    bs.push_back(wc[7:0]);
    bs.push_back(wc[15:8]);
    bs.push_back(8'($urandom));
    if (is_long) begin
      for (int n = 0; n < wc; n++) begin
        logic [7:0] b;
        b = 8'($urandom);
        pl.push_back(b);
        bs.push_back(b);
      end
      bs.push_back(8'($urandom));
      bs.push_back(8'($urandom));
    end
    while (bs.size() % 4 != 0) bs.push_back(8'($urandom));
    nwords = bs.size() / 4;

    if (miss != 4'h0) exp_err++;
    else if (di == 8'h00) m_sof = 1;
    else if (di == 8'h2B && wc != 0) begin
      for (int g = 0; g < wc / 5; g++) begin
        logic [3:0][9:0] p;
        for (int k = 0; k < 4; k++) p[k] = {pl[5*g+k], pl[5*g+4][2*k +: 2]};
        for (int w = 0; w < 2; w++) begin
          logic first;
          first = (g == 0) && (w == 0);
          expq.push_back({first & m_sof, first, p[2*w+1], p[2*w]});
        end
      end
      if (wc >= 5) m_sof = 0;
    end

    for (int t = 0; t <= nwords; t++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        int idx;
        idx = late[i] ? t - 1 : t;
        lane_byte[8*i +: 8] = (idx >= 0 && idx < nwords) ? bs[4*idx+i] : 8'($urandom);
        lane_sot[i] = !miss[i] && (t == (late[i] ? 1 : 0));
      end
    end
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      lane_sot = 4'h0;
      lane_byte = $urandom;
    end
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R11 words not delivered: got %0d left expected 0", expq.size());
    end
    checks++;
    if (got_err != exp_err) begin
      fails++;
      $display("FAIL R9 skew error count: got %0d expected %0d", got_err, exp_err);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    checks++;
    if (pix_vld !== 1'b0 || align_err !== 1'b0 || pix_sof !== 1'b0 || pix_sol !== 1'b0) begin
      fails++;
      $display("FAIL R1 outputs in reset: got %b%b%b%b expected 0000",
               pix_vld, align_err, pix_sof, pix_sol);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (pix_vld !== 1'b0 || align_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 outputs after reset: got %b%b expected 00", pix_vld, align_err);
    end

    // R7 frame start then R4 smallest lines, R10 count not a multiple of 4
    send(8'h00, 16'h1234, 0, 4'h0, 4'h0);
    send(8'h2B, 10, 1, 4'h0, 4'h0);
    send(8'h2B, 5, 1, 4'h0, 4'h0);
    // R2 every kind of lane skew
    send(8'h2B, 20, 1, 4'b0001, 4'h0);
    send(8'h2B, 20, 1, 4'b1000, 4'h0);
    send(8'h2B, 20, 1, 4'b0110, 4'h0);
    send(8'h2B, 20, 1, 4'b1111, 4'h0);
    // R11 longest line the FIFO must hold
    send(8'h2B, 75, 1, 4'b1010, 4'h0);
    // R8 other types keep the frame marker pending for the next line
    send(8'h00, 0, 0, 4'h0, 4'h0);
    send(8'h2A, 20, 1, 4'h0, 4'h0);
    send(8'h02, 0, 0, 4'b0100, 4'h0);
    send(8'h01, 0, 0, 4'h0, 4'h0);
    send(8'h2B, 15, 1, 4'h0, 4'h0);
    // R9 missing lane, early and late variants
    send(8'h2B, 20, 1, 4'h0, 4'b1000);
    send(8'h2B, 20, 1, 4'b0011, 4'b0100);
    send(8'h00, 0, 0, 4'h0, 4'b0001);
    send(8'h2B, 10, 1, 4'h0, 4'h0);

    for (int n = 0; n < 60; n++) begin
      int r;
      logic [3:0] late, miss;
      r = $urandom % 10;
      late = 4'($urandom);
      miss = ($urandom % 10 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      if (r < 6)       send(8'h2B, 5 * (1 + $urandom % 15), 1, late, miss);
      else if (r == 6) send(8'h00, 0, 0, late, miss);
      else if (r == 7) send(8'h2A, 1 + $urandom % 40, 1, late, miss);
      else if (r == 8) send(8'h02, 0, 0, late, miss);
      else             send(8'h01, 0, 0, late, miss);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule